// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 15-bit virtual address into a 12-bit physical address by reading two one-byte entries from byte-addressed memory. A request carries the virtual address and the page number of the directory page. The walker reads the directory entry selected by the upper index field and checks its valid bit. It then reads the table entry in the page that the directory entry points to, checks that entry's valid bit, and combines the frame number with the in-page offset. Either level can end the walk with its own fault code. A successful translation therefore costs exactly two dependent memory loads.

The memory side is a single read port. The walker raises `mem_req` with an address and holds both until a cycle in which `mem_rsp_valid` is high. That response may come in the same cycle as the request or any number of cycles later. The walker takes one request at a time and accepts it only while `req_ready` is high. It presents its result on `res_valid`, `res_paddr` and `res_fault` and holds them until `res_ack`.

The controller has five states. ST_IDLE moves to ST_READ_PDE when a request is accepted. ST_READ_PDE waits for the directory response. A valid entry leads to ST_READ_PTE, and an invalid one leads to ST_FAULT. ST_READ_PTE waits for the table response. A valid entry leads to ST_DONE, and an invalid one leads to ST_FAULT. ST_DONE and ST_FAULT return to ST_IDLE on the acknowledge.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it is released, `req_ready` is 1, `mem_req` is 0 and `res_valid` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high, and `req_ready` is high only in idle. While a walk or an unacknowledged result is in progress, `req_valid` and the request fields are ignored, and the result reflects the request that was accepted.
- R3: The first read targets address `dir_base*32 + vaddr[14:10]` (entry size of one byte), issued the cycle after acceptance.
- R4: If bit 7 of the directory entry is 0, no second read is made. The result carries `res_fault` = 1 and `res_paddr` = 0.
- R5: After a valid directory entry, the second read targets `entry[6:0]*32 + vaddr[9:5]`.
- R6: If bit 7 of the table entry is 0, the result carries `res_fault` = 2 and `res_paddr` = 0.
- R7: After a valid table entry, `res_paddr = {entry[6:0], vaddr[4:0]}` and `res_fault` = 0. For example, directory page 13, address 0x0214, directory entry 0x83 and table entry 0x8E give 0x1D4.
- R8: `res_valid`, `res_paddr` and `res_fault` stay constant until `res_ack`. One cycle after the acknowledge the walker is idle again.
- R9: While `mem_req` is high and no response has arrived, `mem_addr` does not change.
- R10: A successful walk or a table fault makes exactly two memory reads. A directory fault makes exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 15 | Virtual address to translate |
| req_dir_base | input | 7 | Page number of the directory page |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 12 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid; completes the current read |
| mem_rsp_data | input | 8 | Entry byte: bit 7 valid, bits 6:0 page number |
| res_valid | output | 1 | Result available |
| res_paddr | output | 12 | Physical address (0 on fault) |
| res_fault | output | 2 | 0 none, 1 directory fault, 2 table fault |
| res_ack | input | 1 | Result consumed |

## Verification
The bench builds the walker with its default parameters: 5-bit directory index, 5-bit table index, 5-bit offset and one-byte entries. With these values, the full 32×32 index grid can be swept for two directory pages. The memory contents are computed from the address, so directory faults and table faults are spread across the grid. The response latency cycles through 0, 1 and 2 cycles to cover both same-cycle responses and wait states. Every fourth walk also holds a conflicting request on the input throughout the walk.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PDE,
        ST_READ_PTE,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    localparam logic [1:0] FLT_NONE = 2'd0;
    localparam logic [1:0] FLT_DIR  = 2'd1;
    localparam logic [1:0] FLT_TBL  = 2'd2;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int PN_W        = 7,
    parameter int IDX_W       = 5,
    parameter int OFF_W       = 5,
    parameter int ENTRY_BYTES = 1
) (
    input  logic [PN_W-1:0]       page,
    input  logic [IDX_W-1:0]      index,
    output logic [PN_W+OFF_W-1:0] addr
);
    localparam int AW = PN_W + OFF_W;

    logic [AW-1:0] base_w;
    logic [AW-1:0] step_w;

    // page start plus entry stride
    assign base_w = AW'(page) << OFF_W;
    assign step_w = AW'(index) * AW'(ENTRY_BYTES);
    assign addr   = base_w + step_w;

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
    parameter int ENTRY_W = 8
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               valid,
    output logic [ENTRY_W-2:0] page
);
    // top bit flags a present mapping, the rest names a page
    assign valid = entry[ENTRY_W-1];
    assign page  = entry[ENTRY_W-2:0];

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    output logic       mem_req,
    input  logic       mem_rsp_valid,
    input  logic       ent_valid,
    output logic       rd_level,
    output logic       load_req,
    output logic       load_pde,
    output logic       load_pte,
    output logic       res_valid,
    output logic [1:0] res_fault,
    input  logic       res_ack
);
    walk_state_e state_q, state_d;
    logic [1:0]  fault_q, fault_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= FLT_NONE;
        else        fault_q <= fault_d;
    end

    // next state and fault code
    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_READ_PDE;
                    fault_d = FLT_NONE;
                end
            end
            ST_READ_PDE: begin
                if (mem_rsp_valid) begin
                    if (ent_valid) begin
                        state_d = ST_READ_PTE;
                    end else begin
                        state_d = ST_FAULT;
                        fault_d = FLT_DIR;
                    end
                end
            end
            ST_READ_PTE: begin
                if (mem_rsp_valid) begin
                    if (ent_valid) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_FAULT;
                        fault_d = FLT_TBL;
                    end
                end
            end
            ST_DONE, ST_FAULT: begin
                if (res_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rd_level  = 1'b0;
        load_req  = 1'b0;
        load_pde  = 1'b0;
        load_pte  = 1'b0;
        res_valid = 1'b0;
        res_fault = FLT_NONE;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                load_req  = req_valid;
            end
            ST_READ_PDE: begin
                mem_req  = 1'b1;
                load_pde = mem_rsp_valid && ent_valid;
            end
            ST_READ_PTE: begin
                mem_req  = 1'b1;
                rd_level = 1'b1;
                load_pte = mem_rsp_valid && ent_valid;
            end
            ST_DONE: begin
                res_valid = 1'b1;
            end
            ST_FAULT: begin
                res_valid = 1'b1;
                res_fault = fault_q;
            end
            default: ;
        endcase
    end

    // R2: idle, reading and reporting never overlap
    assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req, res_valid}));

    // R8: result held until acknowledged
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ack) |=> (res_valid && $stable(res_fault)));

    // R4: invalid directory entry ends the walk with the directory code
    assert_dir_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_PDE && mem_rsp_valid && !ent_valid)
            |=> (res_valid && res_fault == FLT_DIR && !mem_req));

    // R6: invalid table entry ends the walk with the table code
    assert_tbl_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ_PTE && mem_rsp_valid && !ent_valid)
            |=> (res_valid && res_fault == FLT_TBL));

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int IDX_W       = 5,
    parameter int OFF_W       = 5,
    parameter int ENTRY_W     = 8,
    parameter int ENTRY_BYTES = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [2*IDX_W+OFF_W-1:0]          req_vaddr,
    input  logic [ENTRY_W-2:0]                req_dir_base,
    output logic                              req_ready,
    output logic                              mem_req,
    output logic [ENTRY_W-1+OFF_W-1:0]        mem_addr,
    input  logic                              mem_rsp_valid,
    input  logic [ENTRY_W-1:0]                mem_rsp_data,
    output logic                              res_valid,
    output logic [ENTRY_W-1+OFF_W-1:0]        res_paddr,
    output logic [1:0]                        res_fault,
    input  logic                              res_ack
);
    localparam int LEVELS = 2;
    localparam int PN_W   = ENTRY_W - 1;
    localparam int VA_W   = LEVELS * IDX_W + OFF_W;
    localparam int PA_W   = PN_W + OFF_W;

    logic            rd_level, load_req, load_pde, load_pte;
    logic            ent_valid;
    logic [PN_W-1:0] ent_page;

    logic [VA_W-1:0] vaddr_q;
    logic [PN_W-1:0] base_q;
    logic [PN_W-1:0] next_page_q;
    logic [PN_W-1:0] frame_q;

    logic [PN_W-1:0] lvl_page [LEVELS];
    logic [PA_W-1:0] lvl_addr [LEVELS];

    pt_entry_decode #(.ENTRY_W(ENTRY_W)) u_decode (
        .entry (mem_rsp_data),
        .valid (ent_valid),
        .page  (ent_page)
    );

    pt_walk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .mem_req       (mem_req),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_valid     (ent_valid),
        .rd_level      (rd_level),
        .load_req      (load_req),
        .load_pde      (load_pde),
        .load_pte      (load_pte),
        .res_valid     (res_valid),
        .res_fault     (res_fault),
        .res_ack       (res_ack)
    );

    // walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            base_q      <= '0;
            next_page_q <= '0;
            frame_q     <= '0;
        end else begin
            if (load_req) begin
                vaddr_q <= req_vaddr;
                base_q  <= req_dir_base;
            end
            if (load_pde) next_page_q <= ent_page;
            if (load_pte) frame_q     <= ent_page;
        end
    end

    assign lvl_page[0] = base_q;
    assign lvl_page[1] = next_page_q;

    // one entry-address generator per table level
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        pt_entry_addr #(
            .PN_W        (PN_W),
            .IDX_W       (IDX_W),
            .OFF_W       (OFF_W),
            .ENTRY_BYTES (ENTRY_BYTES)
        ) u_addr (
            .page  (lvl_page[g]),
            .index (vaddr_q[VA_W-1-g*IDX_W -: IDX_W]),
            .addr  (lvl_addr[g])
        );
    end

    assign mem_addr  = lvl_addr[rd_level];
    assign res_paddr = (res_valid && res_fault == FLT_NONE)
                       ? {frame_q, vaddr_q[OFF_W-1:0]} : '0;

    // R3: first read addresses the directory entry of the accepted request
    assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=>
            (mem_req && mem_addr == ((PA_W'($past(req_dir_base)) << OFF_W)
                + PA_W'($past(req_vaddr[VA_W-1 -: IDX_W])) * PA_W'(ENTRY_BYTES))));

    // R9: address holds while a read waits
    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    // R8: physical address held until acknowledged
    assert_paddr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ack) |=> $stable(res_paddr));

endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [14:0] req_vaddr = '0;
    logic [6:0]  req_dir_base = '0;
    logic        req_ready;
    logic        mem_req;
    logic [11:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        res_valid;
    logic [11:0] res_paddr;
    logic [1:0]  res_fault;
    logic        res_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int dir_faults = 0;
    int tbl_faults = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pt_walker u_pt_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_dir_base  (req_dir_base),
        .req_ready     (req_ready),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_paddr     (res_paddr),
        .res_fault     (res_fault),
        .res_ack       (res_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [11:0] a);
        logic [7:0] b;
        if (a == 12'h1A0) return 8'h83;
        if (a == 12'd112) return 8'h8E;
        b[6:0] = 7'((int'(a) * 37 + 11) % 128);
        b[7]   = (int'(a) % 9) != 4;
        return b;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic walk(input logic [6:0] base, input logic [14:0] va, input int lat,
                        input bit busy, input bit expect_example);
        int d, t, o, reads, waits, guard;
        logic [11:0] a1, a2, cur, got_a [2];
        logic [7:0] e1, e2;
        int exp_fault, exp_pa, exp_reads;
        bit newrd;
        logic [11:0] pa_s;
        logic [1:0] f_s;

        d = int'(va[14:10]); t = int'(va[9:5]); o = int'(va[4:0]);
        a1 = 12'(int'(base) * 32 + d);
        e1 = mem_byte(a1);
        a2 = '0; exp_pa = 0;
        if (!e1[7]) begin
            exp_fault = 1; exp_reads = 1;
        end else begin
            a2 = 12'(int'(e1[6:0]) * 32 + t);
            e2 = mem_byte(a2);
            exp_reads = 2;
            if (!e2[7]) exp_fault = 2;
            else begin
                exp_fault = 0;
                exp_pa = int'(e2[6:0]) * 32 + o;
            end
        end

        // issue
        req_valid = 1'b1; req_vaddr = va; req_dir_base = base;
        @(posedge clk); #1;
        if (busy) begin
            req_vaddr = va ^ 15'h5555; req_dir_base = base ^ 7'h55;
        end else req_valid = 1'b0;

        reads = 0; waits = 0; newrd = 1; cur = '0; guard = 0;
        got_a[0] = '0; got_a[1] = '0;
        forever begin
            @(negedge clk);
            guard++;
            if (res_valid || guard > 40) break;
            if (busy) chk(req_ready == 1'b0, "R2 not ready while busy", int'(req_ready), 0);
            if (mem_req) begin
                if (newrd) begin
                    cur = mem_addr; waits = 0; newrd = 0;
                    if (reads < 2) got_a[reads] = mem_addr;
                end else
                    chk(mem_addr == cur, "R9 address stable", int'(mem_addr), int'(cur));
                if (waits == lat) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = mem_byte(cur);
                    reads++; newrd = 1;
                end else begin
                    mem_rsp_valid = 1'b0; waits++;
                end
            end else mem_rsp_valid = 1'b0;
        end
        mem_rsp_valid = 1'b0;
        req_valid = 1'b0;

        chk(res_valid == 1'b1, "R8 result presented", int'(res_valid), 1);
        chk(got_a[0] == a1, "R3 directory entry address", int'(got_a[0]), int'(a1));
        if (exp_reads == 2)
            chk(got_a[1] == a2, "R5 table entry address", int'(got_a[1]), int'(a2));
        chk(reads == exp_reads, "R10 read count", reads, exp_reads);
        if (exp_fault == 1) begin
            dir_faults++;
            chk(res_fault == 2'd1 && res_paddr == 0, "R4 directory fault",
                int'({res_fault, res_paddr}), int'({2'd1, 12'd0}));
        end else if (exp_fault == 2) begin
            tbl_faults++;
            chk(res_fault == 2'd2 && res_paddr == 0, "R6 table fault",
                int'({res_fault, res_paddr}), int'({2'd2, 12'd0}));
        end else begin
            chk(res_fault == 2'd0 && int'(res_paddr) == exp_pa, "R7 physical address",
                int'({res_fault, res_paddr}), exp_pa);
            if (busy) chk(int'(res_paddr) == exp_pa, "R2 busy request ignored",
                          int'(res_paddr), exp_pa);
        end
        if (expect_example)
            chk(res_paddr == 12'h1D4 && res_fault == 2'd0, "R7 worked example",
                int'(res_paddr), 'h1D4);

        // hold without ack
        pa_s = res_paddr; f_s = res_fault;
        repeat (2) begin
            @(negedge clk);
            chk(res_valid && res_paddr == pa_s && res_fault == f_s, "R8 hold until ack",
                int'({res_valid, res_fault, res_paddr}), int'({1'b1, f_s, pa_s}));
        end
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(req_ready == 1'b1 && res_valid == 1'b0 && mem_req == 1'b0, "R8 idle after ack",
            int'({req_ready, res_valid, mem_req}), 3'b100);
    endtask

    initial begin
        #1;
        chk(req_ready == 1'b1 && mem_req == 1'b0 && res_valid == 1'b0, "R1 in reset",
            int'({req_ready, mem_req, res_valid}), 3'b100);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0 && res_valid == 1'b0, "R1 after reset",
            int'({req_ready, mem_req, res_valid}), 3'b100);

        walk(7'd13, 15'h0214, 1, 1'b0, 1'b1);
        walk(7'd13, 15'h0214, 0, 1'b1, 1'b1);

        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 32; d++) begin
                for (int t = 0; t < 32; t++) begin
                    logic [14:0] va;
                    va = {5'(d), 5'(t), 5'((d * 3 + t * 5) % 32)};
                    walk(p == 0 ? 7'd13 : 7'd127, va, (d + t) % 3, (t % 4) == 1, 1'b0);
                end
            end
        end

        chk(dir_faults > 0, "R4 directory fault reached", dir_faults, 1);
        chk(tbl_faults > 0, "R6 table fault reached", tbl_faults, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule